// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

The arbiter picks one of ten vectored interrupt requests for a CPU and tracks which priority level is in service, so that interrupts can nest. Each request line is already the OR of every source that shares its vector. Each vector has an enable bit and a one-bit level select. The first two vectors can be raised to the top level. All other vectors can be raised only to the middle level. When the select bit is clear, a vector sits at the lowest level.

A request is offered to the CPU only when its level is strictly above the level now in service. Among the eligible requests, the highest level wins. A tie is broken in favour of the lower vector index, which is also the lower vector address. When the CPU acknowledges, the level in service is saved on a small stack and replaced by the winner's level. A return restores the saved level. The arbitration result is registered, so the CPU sees a stable request and address one clock after its inputs change.

Top module: `vec_irq_arbiter`

## Requirements
- R1: Vector index i (0 to 9) is reported on vec_addr_o as 8'h03 + 8*i, which gives 03h for index 0 and 4Bh for index 9.
- R2: Levels are encoded in 2 bits: 0 = none, 1 = low, 2 = high, 3 = top. For vectors 0 and 1, a set bit in lvl_sel_i gives level 3. For vectors 2 to 9, a set bit gives level 2. A clear bit gives level 1 for every vector.
- R3: A vector whose en_i bit is 0 never wins, whatever the state of its request line.
- R4: A request takes part only if its level is strictly greater than cur_lvl_o. When no request qualifies, irq_o is 0.
- R5: Among simultaneous eligible requests, the one with the highest level wins.
- R6: Among eligible requests at the same level, the lowest vector index wins.
- R7: When ack_i is high while irq_o is high and ret_i is low, the current level is pushed and cur_lvl_o takes the winner's level on the next clock. Nesting reaches three deep (levels 1, 2 and 3) without overflowing the stack.
- R8: A high ret_i pops the stack, so cur_lvl_o returns to the level saved before the last acknowledge. A ret_i with an empty stack is ignored. When ret_i and ack_i are high together, ret_i takes priority and ack_i is ignored.
- R9: irq_o and vec_addr_o are registered and reflect the inputs and the level one clock later. vec_addr_o is 0 while irq_o is 0. After reset, irq_o is 0, vec_addr_o is 0 and cur_lvl_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 10 | Request per vector, bit i is vector i |
| en_i | input | 10 | Enable per vector |
| lvl_sel_i | input | 10 | Level select per vector, 1 = raised level |
| ack_i | input | 1 | CPU accepts the offered interrupt |
| ret_i | input | 1 | CPU returns from the interrupt in service |
| irq_o | output | 1 | Interrupt offered to the CPU |
| vec_addr_o | output | 8 | Address of the winning vector |
| cur_lvl_o | output | 2 | Level now in service |

## Verification
Every result of this block is due exactly one rising edge after its cause. After a change of requests, enables or selects, irq_o and vec_addr_o settle at the next edge. After an acknowledge or a return, cur_lvl_o settles at the next edge, and so does the re-arbitration against the new level, because arbitration compares against the next-state level. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. No result is read in the cycle of its cause, and none is read after a second edge could hide a wrong intermediate value.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int NUM_TOP = 2
) (
  input  logic [NUM_VEC-1:0]            req_i,
  input  logic [NUM_VEC-1:0]            en_i,
  input  logic [NUM_VEC-1:0]            sel_i,
  output logic [NUM_VEC-1:0][LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    localparam lvl_t RAISED = (g < NUM_TOP) ? LVL_TOP : LVL_HIGH;
    assign lvl_o[g] = !(req_i[g] && en_i[g]) ? LVL_NONE :
                      sel_i[g] ? RAISED : LVL_LOW;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC = 10,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl_i,
  input  lvl_t                          floor_i,
  output logic                          valid_o,
  output logic [IDX_W-1:0]              idx_o,
  output lvl_t                          lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_NONE;
    // strict compare keeps the lowest index on equal levels
    for (int i = 0; i < NUM_VEC; i++) begin
      if (lvl_i[i] > floor_i && lvl_i[i] > lvl_o) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  lvl_t          din_i,
  output lvl_t          top_o,
  output logic [DW-1:0] depth_o
);
  logic [DEPTH-1:0][LVL_W-1:0] mem_q;
  logic [DW-1:0]               depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      depth_q <= '0;
    end else if (pop_i) begin
      depth_q <= depth_q - 1'b1;
    end else if (push_i) begin
      mem_q[depth_q] <= din_i;
      depth_q        <= depth_q + 1'b1;
    end
  end

  assign top_o   = (depth_q == '0) ? LVL_NONE : mem_q[depth_q - 1'b1];
  assign depth_o = depth_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (depth_q < DW'(DEPTH)));
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC   = 10,
  parameter int NUM_TOP   = 2,
  parameter int STK_DEPTH = 3,
  parameter int ADDR_W    = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] en_i,
  input  logic [NUM_VEC-1:0] lvl_sel_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [1:0]         cur_lvl_o
);
  localparam int IDX_W = $clog2(NUM_VEC);
  localparam int DW    = $clog2(STK_DEPTH + 1);

  logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl;
  logic                          pick_valid;
  logic [IDX_W-1:0]              pick_idx;
  lvl_t                          pick_lvl;
  lvl_t                          cur_q, cur_d, stk_top, win_q;
  logic                          irq_q;
  logic [ADDR_W-1:0]             addr_q;
  logic [DW-1:0]                 depth;
  logic                          push, pop;

  irq_lvl_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) i_map (
    .req_i(req_i), .en_i(en_i), .sel_i(lvl_sel_i), .lvl_o(vec_lvl)
  );

  // arbitrate against next-state level so a fresh ack never re-offers
  irq_prio_pick #(.NUM_VEC(NUM_VEC)) i_pick (
    .lvl_i(vec_lvl), .floor_i(cur_d),
    .valid_o(pick_valid), .idx_o(pick_idx), .lvl_o(pick_lvl)
  );

  assign pop  = ret_i && (depth != '0);
  assign push = !ret_i && ack_i && irq_q;

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) i_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .din_i(cur_q), .top_o(stk_top), .depth_o(depth)
  );

  always_comb begin
    if (pop)       cur_d = stk_top;
    else if (push) cur_d = win_q;
    else           cur_d = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= LVL_NONE;
      win_q  <= LVL_NONE;
      irq_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      cur_q  <= cur_d;
      win_q  <= pick_lvl;
      irq_q  <= pick_valid;
      addr_q <= pick_valid ? ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(pick_idx)
                           : '0;
    end
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = addr_q;
  assign cur_lvl_o  = cur_q;

  p_irq_above_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_q > cur_lvl_o));
  p_ack_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !ret_i) |=> (cur_lvl_o == $past(win_q)));
  p_ret_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth == '0) |=> $stable(cur_lvl_o));
  p_idle_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr_o == '0));
endmodule

// File: tb/test_vec_irq_arbiter.sv
module test_vec_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] req = '0, en = '0, sel = '0;
  logic       ack = 1'b0, ret = 1'b0;
  logic       irq;
  logic [7:0] addr;
  logic [1:0] lvl;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  vec_irq_arbiter i_vec_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .lvl_sel_i(sel),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_addr_o(addr), .cur_lvl_o(lvl)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one rising edge, then sample on the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset irq", irq, 0);
    chk("R9 reset addr", addr, 0);
    chk("R9 reset lvl", lvl, 0);
  endtask

  task automatic t_addr();
    for (int i = 0; i < 10; i++) begin
      req = 10'(1) << i; en = '1; sel = '0;
      step();
      chk($sformatf("R1 addr of vector %0d", i), addr, 3 + 8 * i);
      chk("R9 irq one cycle later", irq, 1);
    end
  endtask

  task automatic t_disable();
    req = '1; en = '0;
    step();
    chk("R3 all disabled irq", irq, 0);
    chk("R3 all disabled addr", addr, 0);
    en = 10'b00_0010_0000;
    step();
    chk("R3 only vector 5 enabled", addr, 8'h2B);
  endtask

  task automatic t_order();
    en = '1; sel = '0; req = 10'b00_1000_1000;
    step();
    chk("R6 tie lowest index", addr, 8'h1B);
    req = 10'b10_0000_0001; sel = 10'b10_0000_0000;
    step();
    chk("R5 high beats low", addr, 8'h4B);
    req = 10'b10_0000_0010; sel = 10'b10_0000_0010;
    step();
    chk("R5 top beats high", addr, 8'h0B);
    req = 10'b00_0000_0011; sel = 10'b00_0000_0011;
    step();
    chk("R6 top tie lowest index", addr, 8'h03);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic t_nest();
    en = '1; sel = '0; req = 10'b00_0001_0000;
    step();
    pulse_ack();
    chk("R7 low level taken", lvl, 1);
    chk("R4 equal level blocked", irq, 0);
    req = 10'b00_0101_0000; sel = 10'b00_0100_0000;
    step();
    chk("R2 vector 6 raised is high", addr, 8'h33);
    pulse_ack();
    chk("R7 high level taken", lvl, 2);
    chk("R4 after high ack", irq, 0);
    req = 10'b00_0101_0001; sel = 10'b00_0100_0001;
    step();
    chk("R2 vector 0 raised is top", addr, 8'h03);
    pulse_ack();
    chk("R7 top level taken", lvl, 3);
    chk("R4 nothing above top", irq, 0);
    req = '0;
    pulse_ret();
    chk("R8 pop to high", lvl, 2);
    pulse_ret();
    chk("R8 pop to low", lvl, 1);
    pulse_ret();
    chk("R8 pop to none", lvl, 0);
    pulse_ret();
    chk("R8 empty pop ignored", lvl, 0);
    req = 10'b00_0000_0100;
    step();
    chk("R4 low offered at none", irq, 1);
    ack = 1'b1; ret = 1'b1; step(); ack = 1'b0; ret = 1'b0;
    chk("R8 ret wins over ack", lvl, 0);
    pulse_ack();
    chk("R7 single ack low", lvl, 1);
    pulse_ret();
    chk("R8 return after single", lvl, 0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_disable();
    t_order();
    t_nest();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule